// File: doc/BRIEF.md
# Two-Stage Serial Clock Divider

This block produces the serial clock of a synchronous serial master from the system clock. The division happens in two cascaded counters. The first is a prescaler that accepts only even divisors from 2 to 254. The second divides by one more than an 8-bit scale value, which covers 1 to 256. One serial period therefore lasts prescale × (1 + scale) system cycles, and the high and low phases are always equal.

Internally the prescaler ticks once every prescale/2 cycles. The second stage counts (1 + scale) of those ticks for each half period. Next to the clock level, the block gives one-cycle strobes in the cycles where the clock leaves its idle level and where it returns to it, so a shifter can launch and capture data on them.

New divider values take effect only while the block is disabled or at the end of a full period. A settings change therefore never produces a short pulse.

Top module: `serial_rate_gen`

## Requirements
- R1: With an effective prescale P and scale S, each clock phase lasts (P/2)·(S+1) system cycles. After enable rises, the first leading edge comes (P/2)·(S+1) cycles later, the first trailing edge at twice that, and the second leading edge at three times that.
- R2: Bit 0 of `prescale` is ignored, so 5 divides like 4 and 7 divides like 6.
- R3: A `prescale` of 0 (or 1) divides like 2.
- R4: The second-stage divisor is `scale` + 1, covering 1 (scale 0) to 256 (scale 255).
- R5: While `en` is low, `sclk` equals the `cpol` value sampled at the previous clock edge, both strobes are low and both counters are cleared. After re-enable, the timing of R1 restarts from zero.
- R6: `lead_stb` is high for exactly one cycle, in the cycle where `sclk` first leaves the idle level (`sclk` = !cpol). `trail_stb` is high for exactly one cycle, where `sclk` first returns to the idle level.
- R7: A change of `prescale` or `scale` while enabled does not alter the period in progress. It takes effect from the trailing edge that ends that period.
- R8: After reset, `sclk`, `lead_stb` and `trail_stb` are all 0.
- R9: With prescale 2 and scale 0, `sclk` toggles every system cycle, which is the minimum total division of 2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Run the divider; low holds the clock at idle |
| prescale | input | 8 | First-stage divisor, even, 2..254 |
| scale | input | 8 | Second-stage divisor minus one |
| cpol | input | 1 | Idle level of the serial clock |
| sclk | output | 1 | Serial clock |
| lead_stb | output | 1 | One-cycle strobe on leaving idle |
| trail_stb | output | 1 | One-cycle strobe on returning to idle |

## Verification
The divider is driven with several prescale and scale pairs. The minimum division separates an off-by-one in either counter. Odd and zero prescale values show whether bit 0 is masked and whether zero is clamped. A scale of 255 and a prescale of 254 exercise the counters at their largest values. Each pair is run with both polarities, which tells an inverted idle level apart from a phase error. A settings change in mid-period distinguishes immediate reloading from reloading at the period boundary. Dropping enable while the clock is active shows that the clock returns to idle at once and that the counters restart.

// File: rtl/serial_rate_gen.sv
module serial_rate_gen #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [CW-1:0] prescale,
  input  logic [CW-1:0] scale,
  input  logic          cpol,
  output logic          sclk,
  output logic          lead_stb,
  output logic          trail_stb
);
  localparam int HW = CW - 1;
  localparam logic [HW-1:0] HALF_ONE = {{(HW-1){1'b0}}, 1'b1};

  logic [HW-1:0] half_r, pcnt;
  logic [CW-1:0] sc_r, scnt;
  logic          phase, pol_r, lead_q, trail_q;

  wire [HW-1:0] half_in = (prescale[CW-1:1] == '0) ? HALF_ONE : prescale[CW-1:1];
  wire          tick    = (pcnt == half_r - HALF_ONE);
  wire          flip    = tick && (scnt == sc_r);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      half_r  <= HALF_ONE;
      sc_r    <= '0;
      pcnt    <= '0;
      scnt    <= '0;
      phase   <= 1'b0;
      pol_r   <= 1'b0;
      lead_q  <= 1'b0;
      trail_q <= 1'b0;
    end else if (!en) begin
      half_r  <= half_in;
      sc_r    <= scale;
      pcnt    <= '0;
      scnt    <= '0;
      phase   <= 1'b0;
      pol_r   <= cpol;
      lead_q  <= 1'b0;
      trail_q <= 1'b0;
    end else begin
      lead_q  <= flip && !phase;
      trail_q <= flip && phase;
      if (tick) begin
        pcnt <= '0;
        if (flip) begin
          scnt  <= '0;
          phase <= ~phase;
          if (phase) begin
            half_r <= half_in;
            sc_r   <= scale;
          end
        end else begin
          scnt <= scnt + 1'b1;
        end
      end else begin
        pcnt <= pcnt + 1'b1;
      end
    end
  end

  assign sclk      = pol_r ^ phase;
  assign lead_stb  = lead_q;
  assign trail_stb = trail_q;

  a_r8_reset_idle: assert property (@(posedge clk) $rose(rst_n) |-> !lead_stb && !trail_stb);

  a_r5_idle_level: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (sclk == $past(cpol)) && !lead_stb && !trail_stb);

  a_r6_lead_active: assert property (@(posedge clk) disable iff (!rst_n)
    lead_stb |-> (sclk != pol_r) && $past(sclk) == pol_r);

  a_r6_trail_idle: assert property (@(posedge clk) disable iff (!rst_n)
    trail_stb |-> (sclk == pol_r) && $past(sclk) != pol_r);

  a_r6_lead_single: assert property (@(posedge clk) disable iff (!rst_n)
    lead_stb |=> !lead_stb);

  a_r7_hold_settings: assert property (@(posedge clk) disable iff (!rst_n)
    $past(en) && !trail_stb |-> $stable(half_r) && $stable(sc_r));
endmodule

// File: tb/tb_serial_rate_gen.sv
module tb_serial_rate_gen;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b0;
  logic [7:0] prescale = 8'd2;
  logic [7:0] scale = 8'd0;
  logic       cpol = 1'b0;
  logic       sclk, lead_stb, trail_stb;

  int vectors = 0;
  int fails = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  serial_rate_gen dut (
    .clk(clk), .rst_n(rst_n), .en(en), .prescale(prescale), .scale(scale),
    .cpol(cpol), .sclk(sclk), .lead_stb(lead_stb), .trail_stb(trail_stb)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 190000 && !done) begin
      done = 1'b1;
      fails = fails + 1;
      $display("FAIL watchdog: actual %0d cycles, expected fewer than 190000", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int phase_len(input logic [7:0] p, input logic [7:0] s);
    int h;
    h = (p >> 1) == 0 ? 1 : int'(p >> 1);
    return h * (int'(s) + 1);
  endfunction

  task automatic run_pattern(input logic [7:0] p, input logic [7:0] s, input logic pol, input string req);
    int n, first, trail, second, stbs, lvl;
    n = phase_len(p, s);
    first = 0; trail = 0; second = 0; stbs = 0; lvl = -1;
    en = 1'b0; prescale = p; scale = s; cpol = pol;
    @(negedge clk); @(negedge clk);
    chk(sclk == pol, {req, "/R5 idle level"}, sclk, pol);
    en = 1'b1;
    for (int i = 1; i <= 3 * n; i++) begin
      @(negedge clk);
      if (lead_stb) begin
        stbs++;
        if (first == 0) begin first = i; lvl = sclk; end
        else if (second == 0) second = i;
      end
      if (trail_stb) begin
        stbs++;
        if (trail == 0) trail = i;
      end
    end
    chk(first == n, {req, "/R1 first lead"}, first, n);
    chk(trail == 2 * n, {req, "/R1 trail"}, trail, 2 * n);
    chk(second == 3 * n, {req, "/R1 second lead"}, second, 3 * n);
    chk(lvl == int'(!pol), {req, "/R6 level at lead"}, lvl, int'(!pol));
    chk(stbs == 3, {req, "/R6 strobe cycles"}, stbs, 3);
    en = 1'b0;
    @(negedge clk);
  endtask

  task automatic test_reset();
    chk(sclk == 1'b0, "R8 sclk", sclk, 0);
    chk(!lead_stb && !trail_stb, "R8 strobes", lead_stb + trail_stb, 0);
  endtask

  task automatic test_midchange();
    int lead1, trail1, lead2, trail2;
    lead1 = 0; trail1 = 0; lead2 = 0; trail2 = 0;
    en = 1'b0; prescale = 8'd4; scale = 8'd1; cpol = 1'b0;
    @(negedge clk); @(negedge clk);
    en = 1'b1;
    for (int i = 1; i <= 40; i++) begin
      @(negedge clk);
      if (lead_stb) begin
        if (lead1 == 0) begin
          lead1 = i;
          prescale = 8'd8; scale = 8'd2;
        end else if (lead2 == 0) lead2 = i;
      end
      if (trail_stb) begin
        if (trail1 == 0) trail1 = i;
        else if (trail2 == 0) trail2 = i;
      end
    end
    chk(lead1 == 4, "R7 old first lead", lead1, 4);
    chk(trail1 == 8, "R7 old period kept", trail1, 8);
    chk(lead2 == 20, "R7 new phase length", lead2, 20);
    chk(trail2 == 32, "R7 new period", trail2, 32);
    en = 1'b0;
    @(negedge clk);
  endtask

  task automatic test_disable();
    int bad, first;
    bad = 0; first = 0;
    en = 1'b0; prescale = 8'd2; scale = 8'd1; cpol = 1'b0;
    @(negedge clk); @(negedge clk);
    en = 1'b1;
    @(negedge clk); @(negedge clk);
    chk(sclk == 1'b1 && lead_stb, "R5 active before drop", sclk, 1);
    en = 1'b0; cpol = 1'b1;
    @(negedge clk);
    chk(sclk == 1'b1, "R5 idle follows cpol", sclk, 1);
    cpol = 1'b0;
    @(negedge clk);
    chk(sclk == 1'b0, "R5 idle level low", sclk, 0);
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      if (sclk != 1'b0 || lead_stb || trail_stb) bad++;
    end
    chk(bad == 0, "R5 held idle", bad, 0);
    cpol = 1'b1;
    @(negedge clk);
    en = 1'b1;
    for (int i = 1; i <= 4; i++) begin
      @(negedge clk);
      if (lead_stb && first == 0) first = i;
    end
    chk(first == 2, "R5 restart from zero", first, 2);
    chk(sclk == 1'b1, "R5 back to idle after trail", sclk, 1);
    en = 1'b0;
    @(negedge clk);
  endtask

  task automatic test_min_div();
    int toggles;
    logic prev;
    toggles = 0;
    en = 1'b0; prescale = 8'd2; scale = 8'd0; cpol = 1'b0;
    @(negedge clk); @(negedge clk);
    en = 1'b1;
    @(negedge clk);
    prev = sclk;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (sclk != prev) toggles++;
      prev = sclk;
    end
    chk(toggles == 10, "R9 toggles every cycle", toggles, 10);
    en = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    test_reset();
    rst_n = 1'b1;
    @(negedge clk);
    run_pattern(8'd2, 8'd0, 1'b0, "R9 min");
    run_pattern(8'd5, 8'd2, 1'b0, "R2 odd 5");
    run_pattern(8'd7, 8'd1, 1'b1, "R2 odd 7");
    run_pattern(8'd0, 8'd3, 1'b1, "R3 zero");
    run_pattern(8'd1, 8'd0, 1'b0, "R3 one");
    run_pattern(8'd2, 8'd255, 1'b0, "R4 max scale");
    run_pattern(8'd254, 8'd3, 1'b1, "R1 max prescale");
    test_midchange();
    test_disable();
    test_min_div();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule